// File: doc/BRIEF.md
# Image Sensor Readout Sequencer

This block produces the timing that reads a pixel array out one frame at a time. A readout always opens with a frame overhead phase, in which the charge gathered on every pixel moves into its in-pixel storage. The lines are then read in turn. Each line opens with a row overhead phase and then steps through the column kernels, each kernel being a group of four pixels. The block reports which phase is running, the current row and the current kernel, together with frame-valid and line-valid flags.

Integration of the next frame runs alongside the readout of the previous one. Integration has two control sources. In internal-timer mode a programmable timer runs integration back to back and requests a readout each time a period ends. In pin mode three external pins start integration, end it (which requests a readout) or abandon it. The readout sequence is the same in both modes. If a readout request arrives while a frame is still being read, it is held and served as soon as that frame finishes.

All sequencing runs on a core rate equal to the input clock divided by four. The block implements this with a clock enable instead of a second clock.

Top module: `prs_readout_seq`

## Requirements
- R1: `core_ce` is high for exactly one input-clock cycle in every four. Every output changes only on the clock edge at which `core_ce` is high, which is called a core tick below.
- R2: While `rst_n` is low, every output is 0.
- R3: A frame readout starts with `fot_active` high for `fot_len` core ticks, or one tick when `fot_len` is 0. `frame_valid` stays low during this phase and rises on the tick at which it ends.
- R4: Every line starts with `rot_active` high for `rot_len` core ticks, or one tick when `rot_len` is 0. `line_valid` rises only on the tick at which this phase ends.
- R5: While `line_valid` is high, `kernel_idx` steps through 0, 1, ..., NUM_KERNELS-1 (160 by default), one value per core tick. At all other times it is 0.
- R6: `row_idx` counts 0 to NUM_LINES-1 (480 by default) through a frame. After the last kernel of the last line, `frame_valid` falls and `row_idx` returns to 0.
- R7: When `master_mode` is 1, `integrating` stays high and the internal timer requests a readout every `int_len` core ticks. When a frame takes fewer ticks than that, successive frame overhead phases start exactly `int_len` ticks apart.
- R8: A readout request that arrives during a readout is held. The next frame overhead phase then starts on the tick right after the last kernel, so frames follow each other every `fot_len + NUM_LINES*(rot_len + NUM_KERNELS)` ticks. Any number of requests during one readout yields only one extra frame.
- R9: When `master_mode` is 0, a tick that sees `ext_start` high sets `integrating`. A tick that sees `ext_stop` high while integrating clears `integrating` and starts the frame overhead phase on that same tick.
- R10: When `master_mode` is 0, `ext_abort` clears `integrating` without starting a readout. `ext_stop` has no effect when the block is not integrating.
- R11: Integration and readout overlap. In pin mode, `ext_start` is accepted during a readout and leaves the readout running. In internal-timer mode, `integrating` stays high during every readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (core rate is one quarter of it) |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: internal integration timer, 0: pin-controlled integration |
| fot_len | input | CNT_W | Frame overhead length in core ticks |
| rot_len | input | CNT_W | Row overhead length in core ticks |
| int_len | input | CNT_W | Integration period in core ticks (timer mode) |
| ext_start | input | 1 | Pin mode: begin integration |
| ext_stop | input | 1 | Pin mode: end integration and request a readout |
| ext_abort | input | 1 | Pin mode: end integration without a readout |
| core_ce | output | 1 | Core-rate enable, one input cycle in four |
| integrating | output | 1 | Pixel integration in progress |
| fot_active | output | 1 | Frame overhead phase |
| rot_active | output | 1 | Row overhead phase |
| frame_valid | output | 1 | Line phases of a frame in progress |
| line_valid | output | 1 | Kernel selection in progress |
| kernel_idx | output | KID_W | Selected kernel within the line |
| row_idx | output | ROW_W | Line being read |

## Verification
The assertions assume that the length inputs do not change while a frame is being read. They also assume that NUM_KERNELS fits in the counter width, and that each external pin pulse lasts one full core period, so that exactly one core tick samples it. The stimulus drives every pin pulse from a falling clock edge and holds it for exactly four input clocks. It changes the overhead lengths only while the block is idle, and it changes the mode only between frames or while a request is already held. The phase-order, index-range and tick-alignment properties then hold in both integration modes.

// File: rtl/prs_pkg.sv
package prs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FOT  = 2'd1,
        PH_ROT  = 2'd2,
        PH_KERN = 2'd3
    } phase_e;
endpackage

// File: rtl/prs_core_div.sv
module prs_core_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ce
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ce;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        div_d.ce  = (div_q.cnt == LAST);
        div_d.cnt = div_d.ce ? '0 : div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign ce = div_q.ce;
endmodule

// File: rtl/prs_integ_ctrl.sv
module prs_integ_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             master_mode,
    input  logic [CNT_W-1:0] int_len,
    input  logic             ext_start,
    input  logic             ext_stop,
    input  logic             ext_abort,
    output logic             integrating,
    output logic             trig
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             integ;
        logic             mode;
    } integ_t;

    integ_t ig_d, ig_q;
    logic [CNT_W-1:0] int_last;
    logic             trig_d;

    always_comb begin
        int_last = (int_len == '0) ? '0 : int_len - 1'b1;
        ig_d     = ig_q;
        trig_d   = 1'b0;
        if (ce) begin
            ig_d.mode = master_mode;
            if (master_mode) begin
                ig_d.integ = 1'b1;
                if (!ig_q.mode) begin
                    ig_d.cnt = '0;
                end else if (ig_q.cnt >= int_last) begin
                    ig_d.cnt = '0;
                    trig_d   = 1'b1;
                end else begin
                    ig_d.cnt = ig_q.cnt + 1'b1;
                end
            end else begin
                ig_d.cnt = '0;
                if (ig_q.mode) begin
                    ig_d.integ = 1'b0;
                end else if (ext_abort) begin
                    ig_d.integ = 1'b0;
                end else if (ext_stop && ig_q.integ) begin
                    ig_d.integ = 1'b0;
                    trig_d     = 1'b1;
                end else if (ext_start) begin
                    ig_d.integ = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ig_q <= '0;
        else        ig_q <= ig_d;
    end

    assign integrating = ig_q.integ;
    assign trig        = trig_d;
endmodule

// File: rtl/prs_readout_fsm.sv
module prs_readout_fsm
    import prs_pkg::*;
#(
    parameter int NUM_LINES   = 480,
    parameter int NUM_KERNELS = 160,
    parameter int CNT_W       = 16,
    localparam int KID_W      = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1,
    localparam int ROW_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             trig,
    input  logic [CNT_W-1:0] fot_len,
    input  logic [CNT_W-1:0] rot_len,
    output logic             fot_active,
    output logic             rot_active,
    output logic             frame_valid,
    output logic             line_valid,
    output logic [KID_W-1:0] kernel_idx,
    output logic [ROW_W-1:0] row_idx
);
    localparam logic [CNT_W-1:0] KERN_LAST = CNT_W'(NUM_KERNELS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(NUM_LINES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic             pend;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [CNT_W-1:0] fot_last, rot_last;

    always_comb begin
        fot_last = (fot_len == '0) ? '0 : fot_len - 1'b1;
        rot_last = (rot_len == '0) ? '0 : rot_len - 1'b1;
        sq_d     = sq_q;
        if (ce) begin
            case (sq_q.ph)
                PH_IDLE: begin
                    if (trig) begin
                        sq_d.ph   = PH_FOT;
                        sq_d.cnt  = '0;
                        sq_d.row  = '0;
                        sq_d.pend = 1'b0;
                    end
                end
                PH_FOT: begin
                    if (trig) sq_d.pend = 1'b1;
                    if (sq_q.cnt >= fot_last) begin
                        sq_d.ph  = PH_ROT;
                        sq_d.cnt = '0;
                    end else begin
                        sq_d.cnt = sq_q.cnt + 1'b1;
                    end
                end
                PH_ROT: begin
                    if (trig) sq_d.pend = 1'b1;
                    if (sq_q.cnt >= rot_last) begin
                        sq_d.ph  = PH_KERN;
                        sq_d.cnt = '0;
                    end else begin
                        sq_d.cnt = sq_q.cnt + 1'b1;
                    end
                end
                PH_KERN: begin
                    if (trig) sq_d.pend = 1'b1;
                    if (sq_q.cnt == KERN_LAST) begin
                        sq_d.cnt = '0;
                        if (sq_q.row == ROW_LAST) begin
                            sq_d.row = '0;
                            if (sq_q.pend || trig) begin
                                sq_d.ph   = PH_FOT;
                                sq_d.pend = 1'b0;
                            end else begin
                                sq_d.ph = PH_IDLE;
                            end
                        end else begin
                            sq_d.row = sq_q.row + 1'b1;
                            sq_d.ph  = PH_ROT;
                        end
                    end else begin
                        sq_d.cnt = sq_q.cnt + 1'b1;
                    end
                end
                default: sq_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{ph: PH_IDLE, cnt: '0, row: '0, pend: 1'b0};
        else        sq_q <= sq_d;
    end

    assign fot_active  = (sq_q.ph == PH_FOT);
    assign rot_active  = (sq_q.ph == PH_ROT);
    assign line_valid  = (sq_q.ph == PH_KERN);
    assign frame_valid = rot_active || line_valid;
    assign kernel_idx  = line_valid ? sq_q.cnt[KID_W-1:0] : '0;
    assign row_idx     = sq_q.row;
endmodule

// File: rtl/prs_readout_seq.sv
module prs_readout_seq #(
    parameter int NUM_LINES   = 480,
    parameter int NUM_KERNELS = 160,
    parameter int CNT_W       = 16,
    parameter int CLK_DIV     = 4,
    localparam int KID_W      = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1,
    localparam int ROW_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_mode,
    input  logic [CNT_W-1:0] fot_len,
    input  logic [CNT_W-1:0] rot_len,
    input  logic [CNT_W-1:0] int_len,
    input  logic             ext_start,
    input  logic             ext_stop,
    input  logic             ext_abort,
    output logic             core_ce,
    output logic             integrating,
    output logic             fot_active,
    output logic             rot_active,
    output logic             frame_valid,
    output logic             line_valid,
    output logic [KID_W-1:0] kernel_idx,
    output logic [ROW_W-1:0] row_idx
);
    logic trig;

    prs_core_div #(.DIV(CLK_DIV)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (core_ce)
    );

    prs_integ_ctrl #(.CNT_W(CNT_W)) i_integ (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (core_ce),
        .master_mode (master_mode),
        .int_len     (int_len),
        .ext_start   (ext_start),
        .ext_stop    (ext_stop),
        .ext_abort   (ext_abort),
        .integrating (integrating),
        .trig        (trig)
    );

    prs_readout_fsm #(
        .NUM_LINES   (NUM_LINES),
        .NUM_KERNELS (NUM_KERNELS),
        .CNT_W       (CNT_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (core_ce),
        .trig        (trig),
        .fot_len     (fot_len),
        .rot_len     (rot_len),
        .fot_active  (fot_active),
        .rot_active  (rot_active),
        .frame_valid (frame_valid),
        .line_valid  (line_valid),
        .kernel_idx  (kernel_idx),
        .row_idx     (row_idx)
    );
endmodule

// File: rtl/prs_readout_seq_chk.sv
module prs_readout_seq_chk #(
    parameter int NUM_LINES   = 480,
    parameter int NUM_KERNELS = 160,
    localparam int KID_W      = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1,
    localparam int ROW_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_ce,
    input logic             integrating,
    input logic             fot_active,
    input logic             rot_active,
    input logic             frame_valid,
    input logic             line_valid,
    input logic [KID_W-1:0] kernel_idx,
    input logic [ROW_W-1:0] row_idx
);
    localparam logic [KID_W-1:0] K_MAX = KID_W'(NUM_KERNELS - 1);
    localparam logic [ROW_W-1:0] R_MAX = ROW_W'(NUM_LINES - 1);

    a_r1_ce_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        core_ce |=> !core_ce);

    a_r1_tick_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(core_ce) |-> $stable({integrating, fot_active, rot_active,
                                     frame_valid, line_valid, kernel_idx, row_idx}));

    a_r3_frame_after_fot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> $past(fot_active));

    a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fot_active, rot_active, line_valid}));

    a_r4_line_after_rot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> $past(rot_active));

    a_r5_kernel_range: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_idx <= K_MAX);

    a_r5_kernel_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |-> kernel_idx == '0);

    a_r6_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= R_MAX);
endmodule

bind prs_readout_seq prs_readout_seq_chk #(
    .NUM_LINES   (NUM_LINES),
    .NUM_KERNELS (NUM_KERNELS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_ce     (core_ce),
    .integrating (integrating),
    .fot_active  (fot_active),
    .rot_active  (rot_active),
    .frame_valid (frame_valid),
    .line_valid  (line_valid),
    .kernel_idx  (kernel_idx),
    .row_idx     (row_idx)
);

// File: tb/test_prs_readout_seq.sv
`timescale 1ns/1ps
module test_prs_readout_seq;
    localparam int LINES = 3;
    localparam int KERNS = 160;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b0;
    logic [CW-1:0] fot_len = 16'd5, rot_len = 16'd4, int_len = 16'd600;
    logic ext_start = 1'b0, ext_stop = 1'b0, ext_abort = 1'b0;
    logic core_ce, integrating, fot_active, rot_active, frame_valid, line_valid;
    logic [7:0] kernel_idx;
    logic [1:0] row_idx;

    always #10 clk = ~clk;

    prs_readout_seq #(.NUM_LINES(LINES), .NUM_KERNELS(KERNS), .CNT_W(CW)) i_prs_readout_seq (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .fot_len(fot_len), .rot_len(rot_len), .int_len(int_len),
        .ext_start(ext_start), .ext_stop(ext_stop), .ext_abort(ext_abort),
        .core_ce(core_ce), .integrating(integrating), .fot_active(fot_active),
        .rot_active(rot_active), .frame_valid(frame_valid), .line_valid(line_valid),
        .kernel_idx(kernel_idx), .row_idx(row_idx)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard queue: row*1000 + kernel
    int exp_q[$];
    task automatic expect_frame();
        for (int r = 0; r < LINES; r++)
            for (int k = 0; k < KERNS; k++)
                exp_q.push_back(r * 1000 + k);
    endtask

    // monitor state
    logic ce_seen = 1'b0;
    int tick = 0, fot_run = 0, rot_run = 0, last_fot = -1, fot_count = 0;
    int exp_fot = 5, exp_rot = 4, integ_bad = 0;
    int intervals[$];
    bit prev_fot = 1'b0, prev_rot = 1'b0, chk_integ = 1'b0;

    always @(posedge clk) ce_seen <= core_ce;

    always @(negedge clk) begin
        int act, e;
        if (rst_n && ce_seen) begin
            tick++;
            if (line_valid) begin
                act = int'(row_idx) * 1000 + int'(kernel_idx);
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected kernel", act, -1);
                else begin
                    e = exp_q.pop_front();
                    chk(act == e, "R5/R6 row*1000+kernel", act, e);
                end
            end
            if (fot_active) begin
                if (!prev_fot) begin
                    fot_count++;
                    if (last_fot >= 0) intervals.push_back(tick - last_fot);
                    last_fot = tick;
                    fot_run  = 0;
                end
                fot_run++;
                chk(!frame_valid, "R3 frame_valid in FOT", int'(frame_valid), 0);
            end else if (prev_fot) begin
                chk(fot_run == exp_fot, "R3 FOT length", fot_run, exp_fot);
                chk(rot_active && frame_valid, "R3 ROT follows FOT", int'(rot_active), 1);
            end
            if (rot_active) begin
                if (!prev_rot) rot_run = 0;
                rot_run++;
                chk(!line_valid, "R4 line_valid in ROT", int'(line_valid), 0);
            end else if (prev_rot) begin
                chk(rot_run == exp_rot, "R4 ROT length", rot_run, exp_rot);
                chk(line_valid && kernel_idx == 8'd0, "R4 kernels follow ROT", int'(line_valid), 1);
            end
            if (chk_integ && frame_valid && !integrating) integ_bad++;
            prev_fot = fot_active;
            prev_rot = rot_active;
        end
    end

    task automatic pin(input int which);
        @(negedge clk);
        case (which)
            0: ext_start = 1'b1;
            1: ext_stop  = 1'b1;
            default: ext_abort = 1'b1;
        endcase
        repeat (4) @(negedge clk);
        ext_start = 1'b0; ext_stop = 1'b0; ext_abort = 1'b0;
    endtask

    task automatic wait_frame_end(input int count);
        wait (fot_count == count);
        @(negedge frame_valid);
        @(negedge clk);
    endtask

    initial begin
        int ce_cnt, ce_adj, n;
        bit prev_ce;
        repeat (6) @(negedge clk);
        // R2: reset state
        chk({core_ce, integrating, fot_active, rot_active, frame_valid, line_valid} == 6'd0
            && kernel_idx == 8'd0 && row_idx == 2'd0, "R2 outputs in reset",
            int'({integrating, fot_active, rot_active, frame_valid, line_valid}), 0);
        rst_n = 1'b1;
        // R1: enable rate
        ce_cnt = 0; ce_adj = 0; prev_ce = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (core_ce) ce_cnt++;
            if (core_ce && prev_ce) ce_adj++;
            prev_ce = core_ce;
        end
        chk(ce_cnt == 10, "R1 core_ce count per 40 clocks", ce_cnt, 10);
        chk(ce_adj == 0, "R1 core_ce adjacent pulses", ce_adj, 0);

        // R10: stop while not integrating is ignored
        pin(1);
        chk(!fot_active && fot_count == 0, "R10 stop while idle", fot_count, 0);
        // R9: start
        pin(0);
        chk(integrating, "R9 start sets integrating", int'(integrating), 1);
        expect_frame();
        pin(1);
        chk(fot_active, "R9 stop starts FOT", int'(fot_active), 1);
        chk(!integrating, "R9 stop clears integrating", int'(integrating), 0);
        // R11: start accepted during readout
        wait (rot_active);
        pin(0);
        chk(integrating && frame_valid, "R11 start during readout", int'(integrating), 1);
        wait_frame_end(1);
        chk(exp_q.size() == 0, "R5 all kernels seen", exp_q.size(), 0);
        chk(row_idx == 2'd0 && !line_valid, "R6 row back to 0", int'(row_idx), 0);
        // R10: abort
        pin(2);
        chk(!integrating, "R10 abort clears integrating", int'(integrating), 1'b0);
        repeat (200) @(negedge clk);
        chk(fot_count == 1 && !fot_active, "R10 abort gives no readout", fot_count, 1);

        // R3/R4: zero lengths act as one tick
        fot_len = '0; rot_len = '0; exp_fot = 1; exp_rot = 1;
        pin(0);
        expect_frame();
        pin(1);
        wait_frame_end(2);
        chk(exp_q.size() == 0, "R3 zero-length frame complete", exp_q.size(), 0);

        // R7: timer mode, period longer than a frame
        fot_len = 16'd3; rot_len = 16'd2; exp_fot = 3; exp_rot = 2; int_len = 16'd600;
        repeat (3) expect_frame();
        chk_integ = 1'b1;
        @(negedge clk); master_mode = 1'b1;
        wait_frame_end(5);
        master_mode = 1'b0;
        chk_integ = 1'b0;
        n = intervals.size();
        chk(intervals[n-2] == 600, "R7 FOT spacing", intervals[n-2], 600);
        chk(intervals[n-1] == 600, "R7 FOT spacing", intervals[n-1], 600);
        chk(integ_bad == 0, "R11 integrating during readout", integ_bad, 0);
        repeat (400) @(negedge clk);
        chk(fot_count == 5 && exp_q.size() == 0, "R7 timer stops in pin mode", fot_count, 5);

        // R8: requests held during readout, merged
        int_len = 16'd100;
        repeat (3) expect_frame();
        @(negedge clk); master_mode = 1'b1;
        wait (fot_count == 7);
        repeat (600) @(negedge clk);
        master_mode = 1'b0;
        wait_frame_end(8);
        n = intervals.size();
        chk(intervals[n-2] == 489, "R8 back-to-back frame", intervals[n-2], 489);
        chk(intervals[n-1] == 489, "R8 held request served", intervals[n-1], 489);
        repeat (400) @(negedge clk);
        chk(fot_count == 8 && exp_q.size() == 0, "R8 requests merged", fot_count, 8);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule